// File: doc/BRIEF.md
# SPI Control Register Read Engine

This block sits on the device side of an SPI link. It decodes control read commands and answers them. The link runs in SPI mode 0: SCLK idles low, the host samples on the rising edge, and the device changes MISO on the falling edge. The block works in the system clock domain. It samples chip select, SCLK and MOSI on that clock, so it assumes they are already synchronous to it and that each SCLK phase lasts at least three system clocks.

While chip select is low, the host first shifts in a 32-bit command word. A valid read command carries four things: a bank selector, a 16-bit start address, a register count, and an odd parity bit. The engine returns the command word, then streams the requested registers on MISO. It fetches each register through a synchronous register-file read port, advancing the address by one after every register. If the register file reports an address as not implemented, the engine sends zero for that register. Once the command word is taken, MOSI has no further meaning. Raising chip select ends the command at any bit.

Command word layout, bit 31 first:
- Bit 31 is the data flag. It is 0 for control.
- Bit 29 is the write flag. It is 0 for a read.
- Bits 27:24 are the bank selector.
- Bits 23:8 are the start address.
- Bits 7:1 are the register count minus one.
- Bit 0 makes the number of ones across all 32 bits odd.

Bits 30 and 28 are ignored.

Top module: `spiCtrlRdEngine`

## Requirements
- R1: While chip select is low, the engine shifts in the command word from MOSI on rising SCLK edges, MSB first. During those 32 bits, MISO stays low.
- R2: The 32 MISO bits that follow the command word repeat that command word, MSB first.
- R3: A word with bit 31 set or bit 29 set is not a control read. For such a word the engine issues no register read, keeps MISO low until chip select rises, and does not raise the error flag.
- R4: A word with an even number of ones fails parity. The engine then issues no read and keeps MISO low for the rest of the command. It holds `hdrErr` high from that point until chip select next falls.
- R5: The engine issues exactly (bits 7:1) + 1 read strobes, from 1 to 128. It sends each register as a 32-bit word, MSB first, right after the repeated command word. After the last register, MISO is low.
- R6: The first read uses selector bits 27:24 and address bits 23:8. Each later read uses the previous address plus one, wrapping from 0xFFFF to 0x0000.
- R7: If `rfRdHit` is low in the cycle after a strobe, the word sent for that register is all zeros, whatever `rfRdData` holds.
- R8: Once the command word is complete, MOSI values have no effect on MISO or on the read sequence.
- R9: When chip select rises at any point, MISO is low from the next clock and no further read is issued. The next command starts afresh.
- R10: After reset, MISO, `rfRdEn` and `hdrErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| spiCsN | input | 1 | Chip select, active low, synchronous to clk |
| spiSclk | input | 1 | SPI clock level, sampled on clk |
| spiMosi | input | 1 | Host-to-device serial data |
| spiMiso | output | 1 | Device-to-host serial data |
| rfRdEn | output | 1 | Register-file read strobe, one clock wide |
| rfRdSel | output | 4 | Bank selector for the read |
| rfRdAddr | output | 16 | Register address for the read |
| rfRdData | input | 32 | Read data, valid the clock after the strobe |
| rfRdHit | input | 1 | High when the address is implemented, valid the clock after the strobe |
| hdrErr | output | 1 | Command word failed parity |

## Verification
The engine is driven with several kinds of command word:
- Single-register and multi-register reads. These separate correct counting from off-by-one strobe counts.
- A run that crosses from implemented to unimplemented addresses, and a run that wraps at 0xFFFF. These show whether zero masking and post-increment work.
- The same read repeated with MOSI held low, held high and toggling. This exposes any leak of MOSI after the command word.
- Bad-parity, write and data words. These must all stay silent, and only the first may raise the error flag.
- A command cut short by chip select, and a maximum-length read of 128 registers. These cover early termination and the count limit.

// File: rtl/spiRdPkg.sv
package spiRdPkg;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 16;
  localparam int SEL_W    = 4;
  localparam int LEN_W    = 7;
  // Command word field positions
  localparam int DNC_POS  = 31;
  localparam int WR_POS   = 29;
  localparam int SEL_LSB  = 24;
  localparam int ADDR_LSB = 8;
  localparam int LEN_LSB  = 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic capBit;    // take one MOSI bit into the command shifter
    logic loadHdr;   // command word accepted as a read
    logic loadOut;   // word boundary: move hold word into output shifter
    logic shiftOut;  // advance output shifter one bit
    logic issueRd;   // fire one register-file read
    logic clrAll;    // return datapath to its idle contents
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HDR    = 2'd1,
    ST_STREAM = 2'd2,
    ST_HALT   = 2'd3
  } rdState_t;
endpackage

// File: rtl/spiRdEdge.sv
module spiRdEdge (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic csNIn,
  output logic sclkRise,
  output logic sclkFall,
  output logic csActive
);
  logic sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkQ <= 1'b0;
    else       sclkQ <= sclkIn;
  end

  assign csActive = ~csNIn;
  assign sclkRise = csActive & sclkIn & ~sclkQ;
  assign sclkFall = csActive & ~sclkIn & sclkQ;
endmodule

// File: rtl/spiRdCtrl.sv
module spiRdCtrl
  import spiRdPkg::*;
#(
  parameter int WORD_BITS = WORD_W
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csActive,
  input  logic      sclkRise,
  input  logic      sclkFall,
  input  logic      hdrParOk,
  input  logic      hdrIsRead,
  input  logic      moreRegs,
  output dpStrobe_t stb,
  output logic      hdrErr
);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

  rdState_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt;
  logic setErr;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    setErr   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        stb.clrAll = 1'b1;
        if (csActive) stateNxt = ST_HDR;
      end
      ST_HDR: begin
        if (!csActive) begin
          stb.clrAll = 1'b1;
          stateNxt   = ST_IDLE;
        end else if (sclkRise) begin
          stb.capBit = 1'b1;
          if (bitCnt == LAST_BIT) begin
            if (!hdrParOk) begin
              setErr   = 1'b1;
              stateNxt = ST_HALT;
            end else if (!hdrIsRead) begin
              stateNxt = ST_HALT;
            end else begin
              stb.loadHdr = 1'b1;
              stateNxt    = ST_STREAM;
            end
          end
        end
      end
      ST_STREAM: begin
        if (!csActive) begin
          stb.clrAll = 1'b1;
          stateNxt   = ST_IDLE;
        end else if (sclkFall) begin
          if (bitCnt == '0) begin
            stb.loadOut = 1'b1;
            stb.issueRd = moreRegs;
          end else begin
            stb.shiftOut = 1'b1;
          end
        end
      end
      ST_HALT: begin
        if (!csActive) begin
          stb.clrAll = 1'b1;
          stateNxt   = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      hdrErr <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && csActive) begin
        bitCnt <= '0;
        hdrErr <= 1'b0;
      end else if (sclkRise && (state == ST_HDR || state == ST_STREAM)) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (setErr) hdrErr <= 1'b1;
    end
  end

  // R4
  errNoRead_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdrErr |-> !stb.issueRd);
  // R2
  outStrobeExcl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadOut, stb.shiftOut, stb.loadHdr}));
  // R9
  noReadIdle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |-> !stb.issueRd);
endmodule

// File: rtl/spiRdData.sv
module spiRdData
  import spiRdPkg::*;
#(
  parameter int WORD_BITS = WORD_W,
  parameter int ADDR_BITS = ADDR_W,
  parameter int SEL_BITS  = SEL_W,
  parameter int LEN_BITS  = LEN_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mosiIn,
  input  dpStrobe_t            stb,
  input  logic [WORD_BITS-1:0] rfRdData,
  input  logic                 rfRdHit,
  output logic                 hdrParOk,
  output logic                 hdrIsRead,
  output logic                 moreRegs,
  output logic                 misoBit,
  output logic                 rfRdEn,
  output logic [SEL_BITS-1:0]  rfRdSel,
  output logic [ADDR_BITS-1:0] rfRdAddr
);
  localparam int CNT_W = LEN_BITS + 1;

  logic [WORD_BITS-1:0] hdrShift, hdrNext, outShift, holdWord;
  logic [ADDR_BITS-1:0] rdAddr;
  logic [SEL_BITS-1:0]  rdSel;
  logic [CNT_W-1:0]     regsLeft;
  logic                 rspPend;

  assign hdrNext   = {hdrShift[WORD_BITS-2:0], mosiIn};
  assign hdrParOk  = ^hdrNext;
  assign hdrIsRead = !hdrNext[DNC_POS] && !hdrNext[WR_POS];
  assign moreRegs  = (regsLeft != '0);
  assign misoBit   = outShift[WORD_BITS-1];
  assign rfRdEn    = stb.issueRd;
  assign rfRdAddr  = rdAddr;
  assign rfRdSel   = rdSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrShift <= '0;
      outShift <= '0;
      holdWord <= '0;
      rdAddr   <= '0;
      rdSel    <= '0;
      regsLeft <= '0;
      rspPend  <= 1'b0;
    end else if (stb.clrAll) begin
      hdrShift <= '0;
      outShift <= '0;
      holdWord <= '0;
      rdAddr   <= '0;
      rdSel    <= '0;
      regsLeft <= '0;
      rspPend  <= 1'b0;
    end else begin
      rspPend <= stb.issueRd;
      if (stb.capBit) hdrShift <= hdrNext;
      if (stb.loadHdr) begin
        holdWord <= hdrNext;
        rdAddr   <= hdrNext[ADDR_LSB +: ADDR_BITS];
        rdSel    <= hdrNext[SEL_LSB +: SEL_BITS];
        regsLeft <= CNT_W'(hdrNext[LEN_LSB +: LEN_BITS]) + 1'b1;
      end
      if (stb.loadOut) begin
        outShift <= holdWord;
        holdWord <= '0;
      end else if (stb.shiftOut) begin
        outShift <= {outShift[WORD_BITS-2:0], 1'b0};
      end
      if (stb.issueRd) begin
        rdAddr   <= rdAddr + 1'b1;
        regsLeft <= regsLeft - 1'b1;
      end
      if (rspPend) holdWord <= rfRdHit ? rfRdData : '0;
    end
  end

  // R6
  addrStep_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueRd |=> rdAddr == $past(rdAddr) + 1'b1);
  // R5
  countGuard_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueRd |-> regsLeft != '0);
  // R7
  missZero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspPend && !rfRdHit && !stb.clrAll) |=> holdWord == '0);
endmodule

// File: rtl/spiCtrlRdEngine.sv
module spiCtrlRdEngine
  import spiRdPkg::*;
#(
  parameter int WORD_BITS = WORD_W,
  parameter int ADDR_BITS = ADDR_W,
  parameter int SEL_BITS  = SEL_W,
  parameter int LEN_BITS  = LEN_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 spiCsN,
  input  logic                 spiSclk,
  input  logic                 spiMosi,
  output logic                 spiMiso,
  output logic                 rfRdEn,
  output logic [SEL_BITS-1:0]  rfRdSel,
  output logic [ADDR_BITS-1:0] rfRdAddr,
  input  logic [WORD_BITS-1:0] rfRdData,
  input  logic                 rfRdHit,
  output logic                 hdrErr
);
  logic sclkRise, sclkFall, csActive;
  logic hdrParOk, hdrIsRead, moreRegs;
  dpStrobe_t stb;

  spiRdEdge uEdge (
    .clk(clk), .rstN(rstN), .sclkIn(spiSclk), .csNIn(spiCsN),
    .sclkRise(sclkRise), .sclkFall(sclkFall), .csActive(csActive)
  );

  spiRdCtrl #(.WORD_BITS(WORD_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .csActive(csActive),
    .sclkRise(sclkRise), .sclkFall(sclkFall),
    .hdrParOk(hdrParOk), .hdrIsRead(hdrIsRead), .moreRegs(moreRegs),
    .stb(stb), .hdrErr(hdrErr)
  );

  spiRdData #(
    .WORD_BITS(WORD_BITS), .ADDR_BITS(ADDR_BITS),
    .SEL_BITS(SEL_BITS), .LEN_BITS(LEN_BITS)
  ) uData (
    .clk(clk), .rstN(rstN), .mosiIn(spiMosi), .stb(stb),
    .rfRdData(rfRdData), .rfRdHit(rfRdHit),
    .hdrParOk(hdrParOk), .hdrIsRead(hdrIsRead), .moreRegs(moreRegs),
    .misoBit(spiMiso), .rfRdEn(rfRdEn), .rfRdSel(rfRdSel), .rfRdAddr(rfRdAddr)
  );

  // R9
  csHighQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |=> !spiMiso);
endmodule

// File: tb/spiCtrlRdEngine_test.sv
`timescale 1ns/1ps
module spiCtrlRdEngine_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiCsN = 1'b1, spiSclk = 1'b0, spiMosi = 1'b0;
  logic spiMiso, rfRdEn, rfRdHit, hdrErr;
  logic [3:0]  rfRdSel;
  logic [15:0] rfRdAddr;
  logic [31:0] rfRdData;

  int checks = 0, errors = 0, rdCount = 0;
  bit done = 0;
  logic [31:0] rx [0:139];

  always #2.5 clk = ~clk;

  spiCtrlRdEngine uut (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .rfRdEn(rfRdEn),
    .rfRdSel(rfRdSel), .rfRdAddr(rfRdAddr), .rfRdData(rfRdData),
    .rfRdHit(rfRdHit), .hdrErr(hdrErr)
  );

  function automatic logic [31:0] expReg(input logic [3:0] s, input logic [15:0] a);
    return (a < 16'h0040) ? {4'hC, s, 8'h5A, a} : 32'h0;
  endfunction

  // register file model: synchronous read, 0x0000..0x003F implemented
  always @(posedge clk) begin
    if (rfRdEn) begin
      rfRdHit  <= (rfRdAddr < 16'h0040);
      rfRdData <= (rfRdAddr < 16'h0040) ? {4'hC, rfRdSel, 8'h5A, rfRdAddr} : 32'hDEAD_BEEF;
      rdCount  <= rdCount + 1;
    end
  end

  function automatic logic [31:0] mkHdr(input bit dnc, input bit wr, input logic [3:0] s,
                                        input logic [15:0] a, input logic [6:0] lenM1, input bit bad);
    logic [31:0] h;
    h = {dnc, 1'b0, wr, 1'b0, s, a, lenM1, 1'b0};
    h[0] = ~^h[31:1];
    if (bad) h[0] = ~h[0];
    return h;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xferBit(input logic b, output logic m);
    spiMosi = b;
    repeat (4) @(negedge clk);
    m = spiMiso;
    spiSclk = 1'b1;
    repeat (4) @(negedge clk);
    spiSclk = 1'b0;
  endtask

  // noise: 0 low, 1 high, 2 toggling MOSI after the command word
  task automatic runCmd(input logic [31:0] hdr, input int nWords, input int noise, input int cutBits);
    logic m, b;
    int total;
    total = (cutBits > 0) ? cutBits : nWords * 32;
    for (int w = 0; w < 140; w++) rx[w] = '0;
    @(negedge clk);
    spiCsN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < total; i++) begin
      if (i < 32) b = hdr[31 - i];
      else if (noise == 0) b = 1'b0;
      else if (noise == 1) b = 1'b1;
      else b = i[0];
      xferBit(b, m);
      rx[i / 32][31 - (i % 32)] = m;
    end
    repeat (4) @(negedge clk);
    spiCsN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic tReset();
    chk("R10 miso", {31'b0, spiMiso}, 32'h0);
    chk("R10 rfRdEn", {31'b0, rfRdEn}, 32'h0);
    chk("R10 hdrErr", {31'b0, hdrErr}, 32'h0);
  endtask

  task automatic tSingle();
    logic [31:0] h;
    int c0;
    h = mkHdr(0, 0, 4'h2, 16'h0005, 7'd0, 0);
    c0 = rdCount;
    runCmd(h, 4, 0, 0);
    chk("R1 miso low during command word", rx[0], 32'h0);
    chk("R2 echo", rx[1], h);
    chk("R6 first register", rx[2], expReg(4'h2, 16'h0005));
    chk("R5 tail zero", rx[3], 32'h0);
    chk("R5 read count 1", rdCount - c0, 1);
  endtask

  task automatic tMulti();
    logic [31:0] h;
    int c0;
    h = mkHdr(0, 0, 4'h0, 16'h003E, 7'd3, 0);
    c0 = rdCount;
    runCmd(h, 7, 0, 0);
    chk("R2 echo multi", rx[1], h);
    chk("R6 reg 3E", rx[2], expReg(4'h0, 16'h003E));
    chk("R6 reg 3F", rx[3], expReg(4'h0, 16'h003F));
    chk("R7 unimplemented 40", rx[4], 32'h0);
    chk("R7 unimplemented 41", rx[5], 32'h0);
    chk("R5 tail zero multi", rx[6], 32'h0);
    chk("R5 read count 4", rdCount - c0, 4);
  endtask

  task automatic tIgnore();
    logic [31:0] h;
    logic [31:0] ref0 [0:5];
    h = mkHdr(0, 0, 4'h1, 16'h0010, 7'd2, 0);
    runCmd(h, 6, 0, 0);
    for (int w = 0; w < 6; w++) ref0[w] = rx[w];
    chk("R8 baseline reg", ref0[3], expReg(4'h1, 16'h0011));
    runCmd(h, 6, 1, 0);
    for (int w = 0; w < 6; w++) chk("R8 mosi high", rx[w], ref0[w]);
    runCmd(h, 6, 2, 0);
    for (int w = 0; w < 6; w++) chk("R8 mosi toggle", rx[w], ref0[w]);
  endtask

  task automatic tParity();
    logic [31:0] h;
    int c0;
    h = mkHdr(0, 0, 4'h0, 16'h0002, 7'd1, 1);
    c0 = rdCount;
    runCmd(h, 4, 1, 0);
    chk("R4 word1 zero", rx[1], 32'h0);
    chk("R4 word2 zero", rx[2], 32'h0);
    chk("R4 no reads", rdCount - c0, 0);
    chk("R4 error flag set", {31'b0, hdrErr}, 32'h1);
    runCmd(mkHdr(0, 0, 4'h0, 16'h0001, 7'd0, 0), 3, 0, 0);
    chk("R4 error cleared by next command", {31'b0, hdrErr}, 32'h0);
    chk("R4 recovery data", rx[2], expReg(4'h0, 16'h0001));
  endtask

  task automatic tNonRead();
    int c0;
    c0 = rdCount;
    runCmd(mkHdr(0, 1, 4'h0, 16'h0003, 7'd1, 0), 4, 0, 0);
    chk("R3 write word silent", rx[1] | rx[2] | rx[3], 32'h0);
    chk("R3 write no error", {31'b0, hdrErr}, 32'h0);
    runCmd(mkHdr(1, 0, 4'h0, 16'h0003, 7'd1, 0), 4, 0, 0);
    chk("R3 data word silent", rx[1] | rx[2] | rx[3], 32'h0);
    chk("R3 data no error", {31'b0, hdrErr}, 32'h0);
    chk("R3 no reads", rdCount - c0, 0);
  endtask

  task automatic tWrap();
    logic [31:0] h;
    h = mkHdr(0, 0, 4'h0, 16'hFFFF, 7'd1, 0);
    runCmd(h, 5, 0, 0);
    chk("R7 FFFF unimplemented", rx[2], 32'h0);
    chk("R6 wrap to 0000", rx[3], expReg(4'h0, 16'h0000));
  endtask

  task automatic tAbort();
    int c0;
    c0 = rdCount;
    runCmd(mkHdr(0, 0, 4'h0, 16'h0000, 7'd7, 0), 0, 0, 80);
    chk("R9 miso low after cs rise", {31'b0, spiMiso}, 32'h0);
    chk("R9 reads before cut", rdCount - c0, 2);
    repeat (100) @(negedge clk);
    chk("R9 no reads after cut", rdCount - c0, 2);
    runCmd(mkHdr(0, 0, 4'h3, 16'h0020, 7'd0, 0), 3, 0, 0);
    chk("R9 fresh command echo", rx[1], mkHdr(0, 0, 4'h3, 16'h0020, 7'd0, 0));
    chk("R9 fresh command data", rx[2], expReg(4'h3, 16'h0020));
  endtask

  task automatic tMax();
    int c0;
    c0 = rdCount;
    runCmd(mkHdr(0, 0, 4'h3, 16'h0000, 7'd127, 0), 131, 0, 0);
    for (int r = 0; r < 128; r++)
      chk("R5 max length word", rx[r + 2], expReg(4'h3, 16'(r)));
    chk("R5 max tail zero", rx[130], 32'h0);
    chk("R5 read count 128", rdCount - c0, 128);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tSingle();
    tMulti();
    tIgnore();
    tParity();
    tNonRead();
    tWrap();
    tAbort();
    tMax();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule